// File: doc/BRIEF.md
# Transmit Packet Framer with Sticky Underflow

This block assembles an outgoing radio packet one byte per clock from a show-ahead transmit FIFO and hands the bytes to a modulator. After a start strobe it sends a programmed run of preamble bytes. As soon as the FIFO holds data it sends a 16-bit sync word, or that word twice. It then sends the payload drawn from the FIFO and, when enabled, a two-byte checksum. Every byte after the sync word can be XORed with a PN9 whitening sequence. Status pulses mark the end of the sync word and the end of the packet.

Payload length comes either from the first FIFO byte (variable mode) or from a configuration input (fixed mode). If the FIFO is empty at a payload byte slot, the framer stops sending and holds an underflow state. New FIFO data and new start strobes do not move it out of that state. Only the flush strobe does, and the flush strobe also aborts any packet in progress.

Top module: `tx_pkt_framer`

## Requirements
- R1: After synchronous reset, out_valid, sync_sent, pkt_done, busy, underflow and fifo_rd are all low.
- R2: A start strobe sampled while idle is followed by one cycle with no output byte. The framer then emits 0xAA once per cycle, cfg_preamble_len times, and keeps emitting 0xAA while the FIFO is still empty after that count.
- R3: The sync word follows the preamble with cfg_sync_word[15:8] first and then [7:0]. When cfg_sync_long is 1, those two bytes are sent twice, giving four bytes. sync_sent is high in the cycle that carries the last sync byte.
- R4: When cfg_var_len is 1, the first FIFO byte is sent as a length L, and exactly L more FIFO bytes follow it. L = 0 gives a one-byte payload.
- R5: When cfg_var_len is 0, exactly cfg_fixed_len FIFO bytes are sent. cfg_fixed_len is at least 1.
- R6: When cfg_crc_en is 1, two bytes follow the payload, high byte first. They hold a CRC-16 with polynomial 0x8005, initial value 0xFFFF, data processed MSB first, and no final XOR. The CRC covers every byte read from the FIFO before whitening.
- R7: When cfg_white_en is 1, every byte after the sync word is XORed with bits [7:0] of a 9-bit register set to 0x1FF at the end of the sync word. This includes the CRC bytes. After each such byte the register shifts right 8 times, with bit 0 XOR bit 5 entering bit 8.
- R8: pkt_done is high in the cycle that carries the final byte of the packet, which is the last CRC byte or, without CRC, the last payload byte. busy is low from that cycle, and the framer stays idle until the next start.
- R9: If the FIFO is empty at a payload byte slot, the framer outputs no byte and sets underflow. While underflow is set it never asserts fifo_rd, and it asserts fifo_rd only when the FIFO is not empty.
- R10: Underflow stays set, with no output and no FIFO reads, even when new data reaches the FIFO or start is strobed.
- R11: A flush strobe, whether during underflow or mid-packet, returns the framer to idle on the next cycle with busy and underflow low.
- R12: A start strobe while a packet is in progress has no effect on the output byte stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a packet (acted on only when idle) |
| flush | input | 1 | Abort and clear underflow |
| cfg_preamble_len | input | PRE_W | Minimum number of preamble bytes |
| cfg_sync_word | input | 16 | Sync word, high byte sent first |
| cfg_sync_long | input | 1 | Send the sync word twice |
| cfg_var_len | input | 1 | 1: first FIFO byte is the length |
| cfg_fixed_len | input | LEN_W | Payload byte count in fixed mode |
| cfg_crc_en | input | 1 | Append CRC-16 |
| cfg_white_en | input | 1 | Whiten bytes after the sync word |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_rd_data | input | 8 | Head byte of the show-ahead FIFO |
| fifo_rd | output | 1 | Pop the head byte at this edge |
| out_valid | output | 1 | out_data carries a byte this cycle |
| out_data | output | 8 | Byte to the modulator |
| sync_sent | output | 1 | Last sync byte is on out_data |
| pkt_done | output | 1 | Final packet byte is on out_data |
| busy | output | 1 | A packet or underflow is in progress |
| underflow | output | 1 | Sticky FIFO underflow |

## Verification
The checks assume the configuration inputs are held steady while busy is high, that cfg_fixed_len is non-zero in fixed mode, and that the FIFO behaves as a show-ahead queue which pops exactly on fifo_rd. The bench keeps to this by changing configuration only between packets, never using a zero fixed length, and modelling the FIFO as a queue. That queue pops only on fifo_rd and empties on flush. The bench loads the FIFO between clock edges so that the framer always sees a settled head byte.

// File: rtl/tx_framer_pkg.sv
package tx_framer_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;
    localparam int PN_W   = 9;

    localparam logic [BYTE_W-1:0] PREAMBLE_BYTE = 8'hAA;
    localparam logic [CRC_W-1:0]  CRC_POLY      = 16'h8005;
    localparam logic [CRC_W-1:0]  CRC_SEED      = 16'hFFFF;
    localparam logic [PN_W-1:0]   PN_SEED       = 9'h1FF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SYNC,
        ST_PAY,
        ST_CRC,
        ST_UNDER
    } fr_state_e;

    typedef struct packed {
        logic              valid;
        logic              sync_end;
        logic              pkt_end;
        logic [BYTE_W-1:0] data;
    } fr_beat_t;

    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0]  cur,
        input logic [BYTE_W-1:0] din
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = cur;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ din[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

    function automatic logic [PN_W-1:0] pn_step_byte(input logic [PN_W-1:0] cur);
        logic [PN_W-1:0] s;
        s = cur;
        for (int i = 0; i < BYTE_W; i++) begin
            s = {s[0] ^ s[5], s[PN_W-1:1]};
        end
        return s;
    endfunction

endpackage

// File: rtl/tx_framer_crc.sv
module tx_framer_crc
    import tx_framer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc
);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc <= CRC_SEED;
        end else if (en) begin
            crc <= crc_step_byte(crc, din);
        end
    end

endmodule

// File: rtl/tx_framer_pn9.sv
module tx_framer_pn9
    import tx_framer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              seed,
    input  logic              adv,
    output logic [BYTE_W-1:0] mask
);

    logic [PN_W-1:0] lfsr;

    always_ff @(posedge clk) begin
        if (rst || seed) begin
            lfsr <= PN_SEED;
        end else if (adv) begin
            lfsr <= pn_step_byte(lfsr);
        end
    end

    assign mask = lfsr[BYTE_W-1:0];

endmodule

// File: rtl/tx_framer_ctrl.sv
module tx_framer_ctrl
    import tx_framer_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              flush,
    input  logic [PRE_W-1:0]  cfg_preamble_len,
    input  logic [15:0]       cfg_sync_word,
    input  logic              cfg_sync_long,
    input  logic              cfg_var_len,
    input  logic [LEN_W-1:0]  cfg_fixed_len,
    input  logic              cfg_crc_en,
    input  logic              cfg_white_en,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_rd_data,
    input  logic [CRC_W-1:0]  crc_val,
    input  logic [BYTE_W-1:0] white_mask,
    output logic              fifo_rd,
    output logic              crc_init,
    output logic              crc_en,
    output logic              pn_seed,
    output logic              pn_adv,
    output fr_beat_t          beat,
    output logic              busy,
    output logic              underflow
);

    localparam logic [1:0] SYNC_LAST_SHORT = 2'd1;
    localparam logic [1:0] SYNC_LAST_LONG  = 2'd3;

    fr_state_e         st, st_n;
    logic [PRE_W-1:0]  cnt, cnt_n;
    logic [1:0]        idx, idx_n;
    logic [LEN_W-1:0]  rem, rem_n;
    logic              first, first_n;
    fr_beat_t          beat_n;
    logic              last_pay;
    logic [BYTE_W-1:0] wm;
    logic [1:0]        sync_last;

    assign wm        = cfg_white_en ? white_mask : '0;
    assign sync_last = cfg_sync_long ? SYNC_LAST_LONG : SYNC_LAST_SHORT;

    always_comb begin
        st_n     = st;
        cnt_n    = cnt;
        idx_n    = idx;
        rem_n    = rem;
        first_n  = first;
        beat_n   = '0;
        fifo_rd  = 1'b0;
        crc_init = 1'b0;
        crc_en   = 1'b0;
        pn_seed  = 1'b0;
        pn_adv   = 1'b0;
        last_pay = 1'b0;
        if (flush) begin
            st_n = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        st_n  = ST_PRE;
                        cnt_n = '0;
                    end
                end
                ST_PRE: begin
                    beat_n.valid = 1'b1;
                    if (cnt < cfg_preamble_len) begin
                        beat_n.data = PREAMBLE_BYTE;
                        cnt_n       = cnt + 1'b1;
                    end else if (fifo_empty) begin
                        beat_n.data = PREAMBLE_BYTE;
                    end else begin
                        beat_n.data = cfg_sync_word[15:8];
                        idx_n       = 2'd1;
                        st_n        = ST_SYNC;
                    end
                end
                ST_SYNC: begin
                    beat_n.valid = 1'b1;
                    beat_n.data  = idx[0] ? cfg_sync_word[7:0] : cfg_sync_word[15:8];
                    if (idx == sync_last) begin
                        beat_n.sync_end = 1'b1;
                        st_n            = ST_PAY;
                        first_n         = cfg_var_len;
                        rem_n           = cfg_fixed_len;
                        crc_init        = 1'b1;
                        pn_seed         = 1'b1;
                    end else begin
                        idx_n = idx + 2'd1;
                    end
                end
                ST_PAY: begin
                    if (fifo_empty) begin
                        st_n = ST_UNDER;
                    end else begin
                        fifo_rd      = 1'b1;
                        crc_en       = 1'b1;
                        pn_adv       = 1'b1;
                        beat_n.valid = 1'b1;
                        beat_n.data  = fifo_rd_data ^ wm;
                        if (first) begin
                            first_n  = 1'b0;
                            rem_n    = fifo_rd_data;
                            last_pay = (fifo_rd_data == '0);
                        end else begin
                            rem_n    = rem - 1'b1;
                            last_pay = (rem == LEN_W'(1));
                        end
                        if (last_pay) begin
                            if (cfg_crc_en) begin
                                st_n  = ST_CRC;
                                idx_n = 2'd0;
                            end else begin
                                beat_n.pkt_end = 1'b1;
                                st_n           = ST_IDLE;
                            end
                        end
                    end
                end
                ST_CRC: begin
                    pn_adv       = 1'b1;
                    beat_n.valid = 1'b1;
                    beat_n.data  = (idx[0] ? crc_val[7:0] : crc_val[15:8]) ^ wm;
                    if (idx[0]) begin
                        beat_n.pkt_end = 1'b1;
                        st_n           = ST_IDLE;
                    end else begin
                        idx_n = 2'd1;
                    end
                end
                ST_UNDER: begin
                    st_n = ST_UNDER;
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            rem   <= '0;
            first <= 1'b0;
            beat  <= '0;
        end else begin
            st    <= st_n;
            cnt   <= cnt_n;
            idx   <= idx_n;
            rem   <= rem_n;
            first <= first_n;
            beat  <= beat_n;
        end
    end

    assign busy      = (st != ST_IDLE);
    assign underflow = (st == ST_UNDER);

endmodule

// File: rtl/tx_pkt_framer.sv
module tx_pkt_framer
    import tx_framer_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             flush,
    input  logic [PRE_W-1:0] cfg_preamble_len,
    input  logic [15:0]      cfg_sync_word,
    input  logic             cfg_sync_long,
    input  logic             cfg_var_len,
    input  logic [LEN_W-1:0] cfg_fixed_len,
    input  logic             cfg_crc_en,
    input  logic             cfg_white_en,
    input  logic             fifo_empty,
    input  logic [7:0]       fifo_rd_data,
    output logic             fifo_rd,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             sync_sent,
    output logic             pkt_done,
    output logic             busy,
    output logic             underflow
);

    logic              crc_init, crc_en, pn_seed, pn_adv;
    logic [CRC_W-1:0]  crc_val;
    logic [BYTE_W-1:0] white_mask;
    fr_beat_t          beat;

    tx_framer_crc u_crc (
        .clk  (clk),
        .rst  (rst),
        .init (crc_init),
        .en   (crc_en),
        .din  (fifo_rd_data),
        .crc  (crc_val)
    );

    tx_framer_pn9 u_pn9 (
        .clk  (clk),
        .rst  (rst),
        .seed (pn_seed),
        .adv  (pn_adv),
        .mask (white_mask)
    );

    tx_framer_ctrl #(
        .PRE_W (PRE_W),
        .LEN_W (LEN_W)
    ) u_ctrl (
        .clk              (clk),
        .rst              (rst),
        .start            (start),
        .flush            (flush),
        .cfg_preamble_len (cfg_preamble_len),
        .cfg_sync_word    (cfg_sync_word),
        .cfg_sync_long    (cfg_sync_long),
        .cfg_var_len      (cfg_var_len),
        .cfg_fixed_len    (cfg_fixed_len),
        .cfg_crc_en       (cfg_crc_en),
        .cfg_white_en     (cfg_white_en),
        .fifo_empty       (fifo_empty),
        .fifo_rd_data     (fifo_rd_data),
        .crc_val          (crc_val),
        .white_mask       (white_mask),
        .fifo_rd          (fifo_rd),
        .crc_init         (crc_init),
        .crc_en           (crc_en),
        .pn_seed          (pn_seed),
        .pn_adv           (pn_adv),
        .beat             (beat),
        .busy             (busy),
        .underflow        (underflow)
    );

    assign out_valid = beat.valid;
    assign out_data  = beat.data;
    assign sync_sent = beat.sync_end;
    assign pkt_done  = beat.pkt_end;

endmodule

// File: rtl/tx_pkt_framer_chk.sv
module tx_pkt_framer_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             flush,
    input logic             cfg_var_len,
    input logic [LEN_W-1:0] cfg_fixed_len,
    input logic             fifo_empty,
    input logic             fifo_rd,
    input logic             out_valid,
    input logic             sync_sent,
    input logic             pkt_done,
    input logic             busy,
    input logic             underflow
);

    // R10
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (underflow && !flush) |=> underflow);

    // R9
    under_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |-> (!fifo_rd && !out_valid));

    // R9
    rd_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> !fifo_empty);

    // R11
    flush_idle_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!busy && !underflow));

    // R3
    sync_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sync_sent |-> (out_valid && busy && !pkt_done));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> (out_valid && !busy));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> (!busy && !out_valid));

    // R5
    fixed_len_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !cfg_var_len) |-> (cfg_fixed_len != '0));

endmodule

bind tx_pkt_framer tx_pkt_framer_chk #(.LEN_W(LEN_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .flush         (flush),
    .cfg_var_len   (cfg_var_len),
    .cfg_fixed_len (cfg_fixed_len),
    .fifo_empty    (fifo_empty),
    .fifo_rd       (fifo_rd),
    .out_valid     (out_valid),
    .sync_sent     (sync_sent),
    .pkt_done      (pkt_done),
    .busy          (busy),
    .underflow     (underflow)
);

// File: tb/tx_pkt_framer_bench.sv
module tx_pkt_framer_bench;

    localparam int F_VAL  = 1 << 8;
    localparam int F_SYNC = 1 << 9;
    localparam int F_DONE = 1 << 10;
    localparam int F_UND  = 1 << 11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       flush = 1'b0;
    logic [7:0] cfg_preamble_len = 8'd0;
    logic [15:0] cfg_sync_word = 16'h0000;
    logic       cfg_sync_long = 1'b0;
    logic       cfg_var_len = 1'b1;
    logic [7:0] cfg_fixed_len = 8'd1;
    logic       cfg_crc_en = 1'b0;
    logic       cfg_white_en = 1'b0;
    logic       fifo_empty = 1'b1;
    logic [7:0] fifo_rd_data = 8'h00;
    logic       fifo_rd;
    logic       out_valid;
    logic [7:0] out_data;
    logic       sync_sent;
    logic       pkt_done;
    logic       busy;
    logic       underflow;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] fq[$];
    logic [7:0] push_q[$];
    logic [7:0] pay[$];
    int         expq[$];

    always #5 clk = ~clk;

    tx_pkt_framer u_tx_pkt_framer (
        .clk              (clk),
        .rst              (rst),
        .start            (start),
        .flush            (flush),
        .cfg_preamble_len (cfg_preamble_len),
        .cfg_sync_word    (cfg_sync_word),
        .cfg_sync_long    (cfg_sync_long),
        .cfg_var_len      (cfg_var_len),
        .cfg_fixed_len    (cfg_fixed_len),
        .cfg_crc_en       (cfg_crc_en),
        .cfg_white_en     (cfg_white_en),
        .fifo_empty       (fifo_empty),
        .fifo_rd_data     (fifo_rd_data),
        .fifo_rd          (fifo_rd),
        .out_valid        (out_valid),
        .out_data         (out_data),
        .sync_sent        (sync_sent),
        .pkt_done         (pkt_done),
        .busy             (busy),
        .underflow        (underflow)
    );

    // Show-ahead FIFO model: pops on posedge, loads staged bytes on negedge.
    always @(clk) begin
        if (clk) begin
            if (flush) fq.delete();
            else if (fifo_rd && fq.size() > 0) void'(fq.pop_front());
        end else begin
            while (push_q.size() > 0) fq.push_back(push_q.pop_front());
        end
        fifo_empty   <= (fq.size() == 0);
        fifo_rd_data <= (fq.size() > 0) ? fq[0] : 8'h00;
    end

    function automatic logic [15:0] ref_crc(logic [15:0] c, logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[15] ^ d[i];
            r = r << 1;
            if (fb) r = r ^ 16'h8005;
        end
        return r;
    endfunction

    function automatic logic [8:0] ref_pn(logic [8:0] s);
        logic [8:0] r = s;
        for (int i = 0; i < 8; i++) r = {r[0] ^ r[5], r[8:1]};
        return r;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%03h expected 0x%03h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Expected per-cycle records starting with the cycle after start is sampled.
    task automatic build(int npre, bit crc_on, bit wh, int total);
        logic [8:0]  s = 9'h1FF;
        logic [15:0] c = 16'hFFFF;
        int nsync = cfg_sync_long ? 4 : 2;
        int n = (pay.size() < total) ? pay.size() : total;
        expq.delete();
        expq.push_back(0);
        for (int i = 0; i < npre; i++) expq.push_back(F_VAL | 8'hAA);
        for (int i = 0; i < nsync; i++) begin
            int b = (i % 2 == 1) ? int'(cfg_sync_word[7:0]) : int'(cfg_sync_word[15:8]);
            expq.push_back(F_VAL | b | ((i == nsync - 1) ? F_SYNC : 0));
        end
        for (int i = 0; i < n; i++) begin
            logic [7:0] o = wh ? (pay[i] ^ s[7:0]) : pay[i];
            c = ref_crc(c, pay[i]);
            s = ref_pn(s);
            expq.push_back(F_VAL | int'(o) | ((i == total - 1 && !crc_on) ? F_DONE : 0));
        end
        if (n < total) begin
            expq.push_back(F_UND);
        end else if (crc_on) begin
            logic [7:0] hi = wh ? (c[15:8] ^ s[7:0]) : c[15:8];
            logic [7:0] lo;
            s  = ref_pn(s);
            lo = wh ? (c[7:0] ^ s[7:0]) : c[7:0];
            expq.push_back(F_VAL | int'(hi));
            expq.push_back(F_VAL | F_DONE | int'(lo));
        end
    endtask

    function automatic int observed();
        return (underflow ? F_UND : 0) | (pkt_done ? F_DONE : 0) |
               (sync_sent ? F_SYNC : 0) | (out_valid ? (F_VAL | int'(out_data)) : 0);
    endfunction

    task automatic push_pay();
        foreach (pay[i]) push_q.push_back(pay[i]);
    endtask

    task automatic run(string tag, int push_idx, int restart_idx);
        if (push_idx < 0) begin
            push_pay();
            wait_cyc(1);
        end
        start = 1'b1;
        wait_cyc(1);
        start = 1'b0;
        check(tag, observed(), expq[0]);
        for (int i = 1; i < expq.size(); i++) begin
            wait_cyc(1);
            start = 1'b0;
            check(tag, observed(), expq[i]);
            if (i == push_idx) push_pay();
            if (i == restart_idx) start = 1'b1;
        end
        start = 1'b0;
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        // R1: reset state
        check("R1", {26'd0, out_valid, sync_sent, pkt_done, busy, underflow, fifo_rd}, 0);

        // Variable length, short sync, CRC, no whitening
        cfg_preamble_len = 8'd3; cfg_sync_word = 16'hD391; cfg_sync_long = 1'b0;
        cfg_var_len = 1'b1; cfg_crc_en = 1'b1; cfg_white_en = 1'b0;
        pay = '{8'd4, 8'h11, 8'h22, 8'h33, 8'h44};
        build(3, 1'b1, 1'b0, 5);
        run("R2 R3 R4 R6 R8", -1, -1);
        wait_cyc(1);
        check("R8 idle after packet", {31'd0, busy}, 0);

        // Fixed length, long sync, whitening, no CRC, start while busy (R12)
        cfg_preamble_len = 8'd2; cfg_sync_word = 16'h2DD4; cfg_sync_long = 1'b1;
        cfg_var_len = 1'b0; cfg_fixed_len = 8'd3; cfg_crc_en = 1'b0; cfg_white_en = 1'b1;
        pay = '{8'hA5, 8'h5A, 8'hFF};
        build(2, 1'b0, 1'b1, 3);
        run("R3 R5 R7 R12", -1, 3);
        wait_cyc(2);
        check("R12 no second packet", {31'd0, busy}, 0);

        // Zero preamble, zero length byte, CRC and whitening
        cfg_preamble_len = 8'd0; cfg_sync_long = 1'b0; cfg_var_len = 1'b1;
        cfg_crc_en = 1'b1; cfg_white_en = 1'b1;
        pay = '{8'd0};
        build(0, 1'b1, 1'b1, 1);
        run("R4 R6 R7", -1, -1);
        wait_cyc(1);

        // Preamble extends while FIFO is empty
        cfg_preamble_len = 8'd2; cfg_crc_en = 1'b0; cfg_white_en = 1'b0;
        pay = '{8'd2, 8'h09, 8'h08};
        build(5, 1'b0, 1'b0, 3);
        run("R2 extended preamble", 4, -1);
        wait_cyc(1);

        // Underflow mid-payload
        cfg_preamble_len = 8'd1; cfg_crc_en = 1'b1;
        pay = '{8'd5, 8'h01, 8'h02};
        build(1, 1'b1, 1'b0, 6);
        run("R9", -1, -1);
        push_q.push_back(8'h07); push_q.push_back(8'h07); push_q.push_back(8'h07);
        wait_cyc(2);
        start = 1'b1;
        wait_cyc(1);
        start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            wait_cyc(1);
            check("R10 sticky underflow", {29'd0, out_valid, underflow, fifo_rd}, 3'b010);
        end
        check("R10 FIFO left untouched", fq.size(), 3);
        flush = 1'b1;
        wait_cyc(1);
        flush = 1'b0;
        check("R11 flush clears underflow", {30'd0, busy, underflow}, 0);
        wait_cyc(2);
        check("R11 stays idle", {30'd0, busy, out_valid}, 0);

        // Flush mid-packet
        cfg_crc_en = 1'b0;
        pay = '{8'd6, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
        push_pay();
        wait_cyc(1);
        start = 1'b1;
        wait_cyc(1);
        start = 1'b0;
        wait_cyc(4);
        flush = 1'b1;
        wait_cyc(1);
        flush = 1'b0;
        check("R11 mid-packet abort", {30'd0, busy, out_valid}, 0);
        wait_cyc(3);
        check("R11 no output after abort", {30'd0, busy, out_valid}, 0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule